// File: doc/BRIEF.md
# Three-Phase Dead-Time Inserter with Lockable Setup

This block turns three raw PWM waveforms into high-side and low-side gate drive pairs. It holds a guard interval on every transition, so that the two switches of a leg are never on at the same time. A byte-wide register, reached through a select/strobe bus, sets up the block:

- A phase-count bit selects one input shared by all legs, or three independent inputs.
- An insertion-enable bit turns the guard interval on or off.
- A 6-bit code sets the length of the guard interval.

Some of these fields lock after they are written, so that a runaway program cannot later shrink or remove the protection.

Each leg has its own down-counter, which restarts on every change of that leg's PWM. The switch being turned off drops at once. The switch being turned on waits until the counter reaches zero. Two enable pins, a clock-enable and an output-enable, must both be high for any drive output to be active.

Top module: `dtgen_top`

## Requirements
- R1: After reset the register reads 0xFF. While `bus_sel` is 1, `bus_rdata` returns all 8 stored bits, including locked ones; while `bus_sel` is 0 it reads 0. Bit 7 is the phase-count bit (1 = three inputs), bit 6 is the insertion enable, and bits 5:0 are the interval code.
- R2: A write is a clock edge with `bus_sel` and `bus_wr` both 1. Only the first write after reset loads bits 5:0; all later writes leave them unchanged.
- R3: Bit 7 takes the written value on every write.
- R4: When the stored bit 7 is 0, or the written bit 7 is 0, bit 6 takes the written value. Otherwise (stored and written bit 7 both 1) bit 6 can only be set, never cleared. A write of 0 to both bits clears both.
- R5: With the code c, the interval D in clock cycles is (c+1)*2 for c < 32, (c-32+17)*4 for 32 <= c < 48, and (c-48+17)*8 for c >= 48.
- R6: With bit 6 = 1, suppose a leg's PWM is sampled high at a clock edge after being low. The low side drops after that edge, and the high side rises D edges later. The falling case is the mirror image.
- R7: With bit 6 = 1, a PWM pulse that lasts less than D + 1 cycles produces no high-side output.
- R8: With bit 7 = 1 and bit 6 = 0, each low side is the exact complement of its high side. The high side follows the sampled PWM with no added interval.
- R9: With bits 7 and 6 both 0, every low side is 0 and each high side follows the sampled PWM.
- R10: With bit 7 = 0, all three legs are driven from `pwm_in[0]`. With bit 7 = 1, leg i uses `pwm_in[i]`.
- R11: All drive outputs are 0 unless `clk_en` and `out_en` are both 1.
- R12: The high side and the low side of one leg are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, qualified by select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| pwm_in | input | 3 | Raw PWM per leg |
| clk_en | input | 1 | Peripheral clock enable |
| out_en | input | 1 | Output enable |
| hs_o | output | 3 | High-side drive per leg |
| ls_o | output | 3 | Low-side drive per leg |

## Verification
The checker watches several rules on every cycle:

- No leg ever has both switches on.
- The outputs are off when either enable is low.
- Once the code has been written, it never changes.
- The insertion enable cannot be dropped while three-input mode is stored and kept.
- The low-side pattern matches the two no-interval modes.

The exact length of the interval for each code range, the suppression of short pulses, and the sharing of one input across legs are shown only by the bench scenarios. Each of these runs after a fresh reset and is compared cycle by cycle with a behavioural model.

// File: rtl/dtgen_pkg.sv
package dtgen_pkg;
  localparam int CFG_W  = 8;
  localparam int CODE_W = 6;
  localparam int CNT_W  = 9;

  typedef struct packed {
    logic              tri_mode;
    logic              ins_en;
    logic [CODE_W-1:0] code;
  } cfg_t;

  // Interval length in clock cycles for a setup code.
  function automatic logic [CNT_W-1:0] interval_cycles(input logic [CODE_W-1:0] c);
    logic [CNT_W-1:0] n;
    if (!c[5]) begin
      n = {4'd0, c[4:0]} + CNT_W'(1);
      return n << 1;
    end else begin
      n = {5'd0, c[3:0]} + CNT_W'(17);
      return c[4] ? (n << 3) : (n << 2);
    end
  endfunction
endpackage

// File: rtl/dtgen_ctrl_reg.sv
module dtgen_ctrl_reg
  import dtgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q
);
  logic code_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= cfg_t'(8'hFF);
      code_done_q <= 1'b0;
    end else if (wr_en) begin
      code_done_q    <= 1'b1;
      cfg_q.tri_mode <= wdata[7];
      if (!code_done_q)
        cfg_q.code <= wdata[CODE_W-1:0];
      if (!cfg_q.tri_mode || !wdata[7])
        cfg_q.ins_en <= wdata[6];
      else
        cfg_q.ins_en <= cfg_q.ins_en | wdata[6];
    end
  end
endmodule

// File: rtl/dtgen_phase.sv
module dtgen_phase
  import dtgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm,
  input  logic [CNT_W-1:0] interval,
  input  logic             ins_en,
  input  logic             tri_mode,
  output logic             hs_raw,
  output logic             ls_raw
);
  logic             pwm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pwm_q <= pwm;
      if (pwm != pwm_q)
        cnt_q <= interval;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign settled = (cnt_q == '0);

  always_comb begin
    if (ins_en) begin
      hs_raw = pwm_q & settled;
      ls_raw = ~pwm_q & settled;
    end else if (tri_mode) begin
      hs_raw = pwm_q;
      ls_raw = ~pwm_q;
    end else begin
      hs_raw = pwm_q;
      ls_raw = 1'b0;
    end
  end
endmodule

// File: rtl/dtgen_top.sv
module dtgen_top
  import dtgen_pkg::*;
#(
  parameter int NLEG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [NLEG-1:0] pwm_in,
  input  logic            clk_en,
  input  logic            out_en,
  output logic [NLEG-1:0] hs_o,
  output logic [NLEG-1:0] ls_o
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] interval;
  logic [NLEG-1:0]  hs_raw, ls_raw;
  logic             drive_ok;

  dtgen_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_sel & bus_wr),
    .wdata (bus_wdata),
    .cfg_q (cfg_q)
  );

  assign bus_rdata = bus_sel ? cfg_q : 8'h00;
  assign interval  = interval_cycles(cfg_q.code);
  assign drive_ok  = clk_en & out_en;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic src;
    assign src = cfg_q.tri_mode ? pwm_in[g] : pwm_in[0];
    dtgen_phase u_ph (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm      (src),
      .interval (interval),
      .ins_en   (cfg_q.ins_en),
      .tri_mode (cfg_q.tri_mode),
      .hs_raw   (hs_raw[g]),
      .ls_raw   (ls_raw[g])
    );
  end

  assign hs_o = drive_ok ? hs_raw : '0;
  assign ls_o = drive_ok ? ls_raw : '0;
endmodule

// File: rtl/dtgen_checker.sv
module dtgen_checker #(
  parameter int NLEG = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [7:0]      bus_wdata,
  input logic [7:0]      cfg_q,
  input logic            clk_en,
  input logic            out_en,
  input logic [NLEG-1:0] hs_o,
  input logic [NLEG-1:0] ls_o
);
  logic seen_wr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_wr_q <= 1'b0;
    else if (bus_sel && bus_wr) seen_wr_q <= 1'b1;
  end

  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_o & ls_o) == '0);

  assert_gated_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && out_en) |-> (hs_o == '0 && ls_o == '0));

  assert_code_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_wr_q |=> $stable(cfg_q[5:0]));

  assert_enable_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[7] && cfg_q[6] && !(bus_sel && bus_wr && !bus_wdata[7])) |=> cfg_q[6]);

  assert_exact_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && out_en && cfg_q[7:6] == 2'b10) |-> (ls_o == ~hs_o));

  assert_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[7:6] == 2'b00) |-> (ls_o == '0));
endmodule

bind dtgen_top dtgen_checker #(.NLEG(NLEG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .cfg_q     (cfg_q),
  .clk_en    (clk_en),
  .out_en    (out_en),
  .hs_o      (hs_o),
  .ls_o      (ls_o)
);

// File: tb/dtgen_tb.sv
`timescale 1ns/1ps
module dtgen_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [2:0] pwm_in = 3'b000;
  logic       clk_en = 1'b0, out_en = 1'b0;
  logic [2:0] hs_o, ls_o;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dtgen_top dut_i (.*);

  // Behavioural model
  int m_cfg = 255;
  bit m_done = 0;
  int m_q[3], m_cnt[3];

  function automatic int interval_of(int c);
    if (c < 32) return (c + 1) * 2;
    if (c < 48) return (c - 32 + 17) * 4;
    return (c - 48 + 17) * 8;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 255; m_done = 0;
      for (int i = 0; i < 3; i++) begin m_q[i] = 0; m_cnt[i] = 0; end
    end else begin
      int d, src, pcn;
      d = interval_of(m_cfg % 64);
      pcn = (m_cfg >> 7) & 1;
      for (int i = 0; i < 3; i++) begin
        src = pcn ? pwm_in[i] : pwm_in[0];
        if (src != m_q[i]) begin m_q[i] = src; m_cnt[i] = d; end
        else if (m_cnt[i] > 0) m_cnt[i]--;
      end
      if (bus_sel && bus_wr) begin
        int nc, ndte, odte, opcn;
        opcn = (m_cfg >> 7) & 1;
        odte = (m_cfg >> 6) & 1;
        nc = m_done ? (m_cfg % 64) : (bus_wdata % 64);
        if (opcn == 1 && bus_wdata[7]) ndte = odte | bus_wdata[6];
        else ndte = bus_wdata[6];
        m_cfg = bus_wdata[7] * 128 + ndte * 64 + nc;
        m_done = 1;
      end
    end
    #1;
    if (rst_n) begin
      int ehs, els, g, pcn, dte;
      pcn = (m_cfg >> 7) & 1; dte = (m_cfg >> 6) & 1;
      g = clk_en && out_en;
      ehs = 0; els = 0;
      for (int i = 0; i < 3; i++) begin
        int h, l;
        if (dte) begin h = m_q[i] && m_cnt[i] == 0; l = !m_q[i] && m_cnt[i] == 0; end
        else if (pcn) begin h = m_q[i]; l = !m_q[i]; end
        else begin h = m_q[i]; l = 0; end
        if (g) begin ehs |= h << i; els |= l << i; end
      end
      check("R6 hs model", hs_o, ehs);
      check("R6 ls model", ls_o, els);
      check("R1 rdata model", bus_rdata, bus_sel ? m_cfg : 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic write_reg(logic [7:0] v);
    bus_sel = 1; bus_wr = 1; bus_wdata = v;
    step(1);
    bus_wr = 0;
  endtask

  task automatic read_reg(string req, int exp);
    bus_sel = 1; #0.5;
    check(req, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; pwm_in = 0; bus_sel = 0; bus_wr = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  // Rising edge on leg 0; count edges until the high side rises.
  task automatic measure(string req, int code);
    int k = 0;
    pwm_in = 3'b000; step(300);
    pwm_in[0] = 1'b1;
    step(1);
    check({req, " low side drops at once"}, ls_o[0], 0);
    k = 1;
    while (!hs_o[0] && k < 400) begin step(1); k++; end
    check(req, k, interval_of(code) + 1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    read_reg("R1 reset value", 8'hFF);
    bus_sel = 1; #0.5; bus_sel = 0; #0.5;
    check("R1 unselected read", bus_rdata, 0);
    clk_en = 1; out_en = 1;

    // R2 / R4: code write-once, enable only settable in three-input mode
    write_reg(8'hC3);
    read_reg("R2 first write", 8'hC3);
    write_reg(8'hFF);
    read_reg("R2 code locked", 8'hC3);
    write_reg(8'h80);
    read_reg("R4 enable not cleared", 8'hC3);
    measure("R5 R6 code 3", 3);

    // R7 short pulse
    pwm_in = 0; step(20);
    begin
      int seen = 0;
      pwm_in[0] = 1; step(4); seen |= hs_o[0];
      pwm_in[0] = 0;
      for (int i = 0; i < 20; i++) begin step(1); seen |= hs_o[0]; end
      check("R7 short pulse suppressed", seen, 0);
    end

    // R6 falling side mirrored
    pwm_in[0] = 1; step(30);
    pwm_in[0] = 0; step(1);
    check("R6 high side drops at once", hs_o[0], 0);
    check("R6 low side still held", ls_o[0], 0);
    step(8);
    check("R6 low side after interval", ls_o[0], 1);

    // R10 three inputs independent
    pwm_in = 3'b010; step(30);
    check("R10 independent legs", hs_o, 3'b010);

    // R11 gating
    out_en = 0; #0.5;
    check("R11 out_en low hs", hs_o, 0);
    check("R11 out_en low ls", ls_o, 0);
    out_en = 1; clk_en = 0; #0.5;
    check("R11 clk_en low", ls_o, 0);
    clk_en = 1;

    // R3 / R4 / R8 / R9
    write_reg(8'h83);
    read_reg("R4 still set", 8'hC3);
    write_reg(8'h03);
    read_reg("R3 R4 both cleared", 8'h03);
    pwm_in = 3'b001; step(2);
    check("R9 hs follows", hs_o, 3'b111);
    check("R9 ls idle", ls_o, 0);
    check("R10 shared input", hs_o, 3'b111);
    write_reg(8'h40);
    read_reg("R4 free set in one-input mode", 8'h43);
    write_reg(8'h00);
    read_reg("R4 free clear in one-input mode", 8'h03);
    write_reg(8'h80);
    read_reg("R3 set three-input", 8'h83);
    pwm_in = 3'b101; step(2);
    check("R8 exact complement hs", hs_o, 3'b101);
    check("R8 exact complement ls", ls_o, 3'b010);

    // R5 other code ranges
    do_reset(); write_reg(8'h40); measure("R5 code 0", 0);
    do_reset(); write_reg(8'h5F); measure("R5 code 31", 31);
    do_reset(); write_reg(8'h62); measure("R5 code 34", 34);
    do_reset(); write_reg(8'h71); measure("R5 code 49", 49);
    do_reset(); write_reg(8'h7F); measure("R5 code 63", 63);

    // R12 random toggling in three-input mode, model compared each cycle
    do_reset(); write_reg(8'hC1);
    for (int i = 0; i < 400; i++) begin
      pwm_in = 3'($urandom);
      step(1 + ($urandom % 12));
      check("R12 no overlap", hs_o & ls_o, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule